// File: doc/BRIEF.md
# Single-Channel Bus-Master Transfer Sequencer

This block moves a programmed run of bytes across a shared system bus that a host processor normally owns. Software programs a start address, a byte count and a command word through a simple write port. When the attached peripheral raises its request, the sequencer asks the host for the bus with a hold request. It waits for the host's hold acknowledge and then enables its address outputs. After that it acknowledges the peripheral and drives read and write strobes for each byte. When the count runs out, it pulses an active-low end-of-process line.

Another agent can cut a transfer short by pulling the end-of-process input low. Whichever way a transfer ends, the sequencer releases the bus and sets a done flag. The command word can switch the whole sequencer off. It also sets the active level of the request input and of the acknowledge output, and it can move the start of the write strobe earlier.

Top module: `dma_xfer_seq`

## Requirements
- R1: A write with select 0 loads the start address, select 1 loads the count and select 2 loads the command word. Select 3 is ignored. A transfer copies the start address and count at the moment it starts.
- R2: While idle and enabled, an active request raises hold_req_o on the next cycle.
- R3: address enable stays low until hold_ack_i has been sampled high, and rises on the cycle after that sample. With a host that answers one cycle late, hold_req_o is high for 2N+5 cycles and addr_en_o for 2N+3 cycles.
- R4: The peripheral acknowledge is active only while address enable is high, and never in the first address-enable cycle. The first cycle gives the address a full cycle to settle.
- R5: Each byte takes two cycles with rd_stb_o high in both cycles. wr_stb_o is high in the second cycle and is never high without rd_stb_o.
- R6: A programmed count N moves N+1 bytes. Byte k is placed at address start+k, modulo 2^16.
- R7: After the last byte, eop_n_o is low for exactly one cycle. In that cycle hold request, address enable, acknowledge and strobes are all inactive, and the block is idle on the next cycle.
- R8: eop_n_i low while the bus is requested or owned ends the transfer at once. On the next cycle hold request, address enable and strobes are low, eop_n_o stays high and done is set.
- R9: Command bit 0 = 1 disables the sequencer, and no hold request is raised.
- R10: Command bit 1 = 1 makes the request active when dev_req_i is low. With bit 1 = 0 the request is active when dev_req_i is high.
- R11: Command bit 2 = 1 makes dev_ack_o active high. With bit 2 = 0 it is active low, so after reset dev_ack_o is 1.
- R12: Command bit 3 = 1 (extended write) also raises wr_stb_o in the first cycle of each byte. With bit 3 = 0 it does not.
- R13: done_o is set when a transfer ends, whether by count or by abort. It is cleared when the next transfer starts, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | 16 | Configuration write data |
| dev_req_i | input | 1 | Peripheral request, polarity from command bit 1 |
| hold_req_o | output | 1 | Bus request toward the host |
| hold_ack_i | input | 1 | Bus grant from the host |
| addr_en_o | output | 1 | Address outputs enabled |
| addr_o | output | 16 | Current transfer address |
| dev_ack_o | output | 1 | Peripheral acknowledge, polarity from command bit 2 |
| rd_stb_o | output | 1 | Read strobe |
| wr_stb_o | output | 1 | Write strobe |
| eop_n_i | input | 1 | External end-of-process, active low |
| eop_n_o | output | 1 | End-of-process driven by the block, active low |
| done_o | output | 1 | Transfer-ended status flag |

## Verification
The hold request appears one cycle after the request is driven. Address enable follows one cycle after the first sampled grant, with a host that answers one cycle late. Each byte then takes two strobe cycles, the end pulse comes one cycle after the final write cycle, and done is visible one cycle after that. The bench drives inputs on falling edges and samples every output on falling edges. It then counts cycles against these closed-form values: 2N+5 hold cycles, 2N+3 address cycles, 2N+2 strobe cycles and a single end pulse. An abort is checked on the very next falling edge after the end-of-process input is pulled low.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int unsigned CMD_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_AEN,
        ST_RD,
        ST_WR,
        ST_END
    } seq_state_e;

    // packed order puts dis at bit 0, req_lo at bit 1, ack_hi at bit 2, ext_wr at bit 3
    typedef struct packed {
        logic ext_wr;
        logic ack_hi;
        logic req_lo;
        logic dis;
    } dma_cmd_t;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [1:0]        sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] base_addr_o,
    output logic [CNT_W-1:0]  base_cnt_o,
    output dma_cmd_t          cmd_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        dma_cmd_t          cmd;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            case (sel_i)
                2'd0:    regs_d.addr = wdata_i[ADDR_W-1:0];
                2'd1:    regs_d.cnt  = wdata_i[CNT_W-1:0];
                2'd2:    regs_d.cmd  = dma_cmd_t'(wdata_i[CMD_W-1:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign base_addr_o = regs_q.addr;
    assign base_cnt_o  = regs_q.cnt;
    assign cmd_o       = regs_q.cmd;

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [CNT_W-1:0]  base_cnt_i,
    input  dma_cmd_t          cmd_i,
    input  logic              req_pin_i,
    input  logic              hold_ack_i,
    input  logic              eop_n_i,
    output logic              hold_req_o,
    output logic              addr_en_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ack_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic              eop_n_o,
    output logic              done_o
);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;
    logic req_on;
    logic abort;

    assign req_on = req_pin_i ^ cmd_i.req_lo;
    assign abort  = !eop_n_i;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (req_on && !cmd_i.dis) begin
                    s_d.st   = ST_HOLD;
                    s_d.addr = base_addr_i;
                    s_d.cnt  = base_cnt_i;
                    s_d.done = 1'b0;
                end
            end
            ST_HOLD: begin
                if (abort) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end else if (hold_ack_i) begin
                    s_d.st = ST_AEN;
                end
            end
            ST_AEN, ST_RD: begin
                if (abort) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.st = (s_q.st == ST_AEN) ? ST_RD : ST_WR;
                end
            end
            ST_WR: begin
                if (abort) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.addr = s_q.addr + ADDR_W'(1);
                    s_d.cnt  = s_q.cnt - CNT_W'(1);
                    s_d.st   = (s_q.cnt == '0) ? ST_END : ST_RD;
                end
            end
            ST_END: begin
                s_d.st   = ST_IDLE;
                s_d.done = 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.addr <= '0;
            s_q.cnt  <= '0;
            s_q.done <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        hold_req_o = (s_q.st == ST_HOLD) || (s_q.st == ST_AEN) ||
                     (s_q.st == ST_RD)   || (s_q.st == ST_WR);
        addr_en_o  = (s_q.st == ST_AEN) || (s_q.st == ST_RD) || (s_q.st == ST_WR);
        ack_o      = (s_q.st == ST_RD) || (s_q.st == ST_WR);
        rd_o       = ack_o;
        wr_o       = (s_q.st == ST_WR) || ((s_q.st == ST_RD) && cmd_i.ext_wr);
        eop_n_o    = (s_q.st != ST_END);
    end

    assign addr_o = s_q.addr;
    assign done_o = s_q.done;

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    input  logic              dev_req_i,
    output logic              hold_req_o,
    input  logic              hold_ack_i,
    output logic              addr_en_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              dev_ack_o,
    output logic              rd_stb_o,
    output logic              wr_stb_o,
    input  logic              eop_n_i,
    output logic              eop_n_o,
    output logic              done_o
);

    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  base_cnt;
    dma_cmd_t          cmd;
    logic              ack_int;

    dma_cfg_regs #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cfg_we_i),
        .sel_i      (cfg_sel_i),
        .wdata_i    (cfg_wdata_i),
        .base_addr_o(base_addr),
        .base_cnt_o (base_cnt),
        .cmd_o      (cmd)
    );

    dma_seq_fsm #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_addr_i(base_addr),
        .base_cnt_i (base_cnt),
        .cmd_i      (cmd),
        .req_pin_i  (dev_req_i),
        .hold_ack_i (hold_ack_i),
        .eop_n_i    (eop_n_i),
        .hold_req_o (hold_req_o),
        .addr_en_o  (addr_en_o),
        .addr_o     (addr_o),
        .ack_o      (ack_int),
        .rd_o       (rd_stb_o),
        .wr_o       (wr_stb_o),
        .eop_n_o    (eop_n_o),
        .done_o     (done_o)
    );

    assign dev_ack_o = cmd.ack_hi ? ack_int : !ack_int;

endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic hold_req_o,
    input logic hold_ack_i,
    input logic addr_en_o,
    input logic ack_int,
    input logic rd_stb_o,
    input logic wr_stb_o,
    input logic eop_n_i,
    input logic eop_n_o,
    input logic done_o,
    input logic cmd_dis
);

    assert_aen_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_en_o) |-> $past(hold_ack_i));

    assert_ack_addr_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_int |-> (addr_en_o && $past(addr_en_o)));

    assert_write_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> rd_stb_o);

    assert_end_releases_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !eop_n_o |-> (!hold_req_o && !addr_en_o && !ack_int && !rd_stb_o));

    assert_abort_drops_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!eop_n_i && addr_en_o) |=> !addr_en_o);

    assert_disabled_no_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_req_o) |-> !$past(cmd_dis));

    assert_done_after_end_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eop_n_o) |=> done_o);

endmodule

bind dma_xfer_seq dma_xfer_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_req_o(hold_req_o),
    .hold_ack_i(hold_ack_i),
    .addr_en_o (addr_en_o),
    .ack_int   (ack_int),
    .rd_stb_o  (rd_stb_o),
    .wr_stb_o  (wr_stb_o),
    .eop_n_i   (eop_n_i),
    .eop_n_o   (eop_n_o),
    .done_o    (done_o),
    .cmd_dis   (cmd.dis)
);

// File: tb/sim_dma_xfer_seq.sv
module sim_dma_xfer_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        dev_req = 1'b0;
    logic        hold_req;
    logic        hold_ack = 1'b0;
    logic        addr_en;
    logic [15:0] addr;
    logic        dev_ack;
    logic        rd_stb;
    logic        wr_stb;
    logic        eop_n_in = 1'b1;
    logic        eop_n_out;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // behavioural host: grants one cycle after the request
    always @(posedge clk) hold_ack <= rst_n ? hold_req : 1'b0;

    dma_xfer_seq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we_i   (cfg_we),
        .cfg_sel_i  (cfg_sel),
        .cfg_wdata_i(cfg_wdata),
        .dev_req_i  (dev_req),
        .hold_req_o (hold_req),
        .hold_ack_i (hold_ack),
        .addr_en_o  (addr_en),
        .addr_o     (addr),
        .dev_ack_o  (dev_ack),
        .rd_stb_o   (rd_stb),
        .wr_stb_o   (wr_stb),
        .eop_n_i    (eop_n_in),
        .eop_n_o    (eop_n_out),
        .done_o     (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // program safely: disabled first, request pin parked at its inactive level
    task automatic setup(input logic [15:0] start, input int n, input logic [3:0] cmd);
        wr_cfg(2'd2, {12'd0, cmd | 4'b0001});
        dev_req = cmd[1];
        wr_cfg(2'd0, start);
        wr_cfg(2'd1, n[15:0]);
        wr_cfg(2'd2, {12'd0, cmd});
    endtask

    task automatic run_xfer(input logic [15:0] start, input int n, input logic [3:0] cmd);
        int hreq_cyc = 0, aen_cyc = 0, rd_k = 0, eop_cnt = 0;
        int bad_addr = 0, bad_wr = 0, bad_ack = 0, bad_rel = 0;
        int first_hreq = -1, done_at_start = -1;
        int tail = -1;
        logic [15:0] exp_a;
        setup(start, n, cmd);
        @(negedge clk);
        dev_req = !cmd[1];
        for (int i = 1; i < 2000 && tail != 0; i++) begin
            @(negedge clk);
            if (tail > 0) tail--;
            if (hold_req) begin
                hreq_cyc++;
                if (first_hreq < 0) begin
                    first_hreq = i;
                    done_at_start = int'(done);
                end
            end
            if (addr_en) begin
                aen_cyc++;
                if (!rd_stb && (dev_ack == cmd[2])) bad_ack++;
            end
            if (rd_stb) begin
                if (dev_ack != cmd[2]) bad_ack++;
                if (rd_k % 2 == 0) begin
                    exp_a = start + 16'(rd_k / 2);
                    if (addr != exp_a) bad_addr++;
                    if (wr_stb != cmd[3]) bad_wr++;
                end else if (!wr_stb) begin
                    bad_wr++;
                end
                rd_k++;
            end
            if (!eop_n_out) begin
                eop_cnt++;
                if (hold_req || addr_en || rd_stb || wr_stb || (dev_ack == cmd[2])) bad_rel++;
                dev_req = cmd[1];
                tail = 2;
            end
        end
        check(first_hreq == 1, "R2 hold request one cycle after request", first_hreq, 1);
        check(done_at_start == 0, "R13 done cleared at start", done_at_start, 0);
        check(hreq_cyc == 2 * n + 5, "R3 hold request cycles", hreq_cyc, 2 * n + 5);
        check(aen_cyc == 2 * n + 3, "R3 address enable cycles", aen_cyc, 2 * n + 3);
        check(rd_k == 2 * (n + 1), "R6 byte count via read cycles", rd_k, 2 * (n + 1));
        check(bad_addr == 0, "R6 R1 byte addresses", bad_addr, 0);
        check(bad_wr == 0, "R5 R12 write strobe timing", bad_wr, 0);
        check(bad_ack == 0, "R4 R11 acknowledge level", bad_ack, 0);
        check(eop_cnt == 1, "R7 single end pulse", eop_cnt, 1);
        check(bad_rel == 0, "R7 bus released at end", bad_rel, 0);
        check(done == 1'b1 && !hold_req, "R13 done and idle after end", int'(done), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        check(!hold_req && !addr_en && !rd_stb && !wr_stb, "R2 reset bus idle", int'(hold_req), 0);
        check(dev_ack == 1'b1, "R11 reset ack inactive high", int'(dev_ack), 1);
        check(eop_n_out == 1'b1 && done == 1'b0, "R13 reset status", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: disabled sequencer ignores an active request
        setup(16'h0100, 2, 4'b0001);
        dev_req = 1'b1;
        cnt = 0;
        repeat (20) begin
            @(negedge clk);
            if (hold_req) cnt++;
        end
        check(cnt == 0, "R9 disabled raises no hold", cnt, 0);

        // R10: active-low request with pin high stays idle
        setup(16'h0100, 2, 4'b0010);
        cnt = 0;
        repeat (20) begin
            @(negedge clk);
            if (hold_req) cnt++;
        end
        check(cnt == 0, "R10 inactive-high pin raises no hold", cnt, 0);

        // R1: select 3 must not disturb the programmed address
        setup(16'h0200, 1, 4'b0000);
        wr_cfg(2'd3, 16'hFFFF);
        dev_req = 1'b1;
        repeat (4) @(negedge clk);
        check(addr == 16'h0200, "R1 select 3 ignored", int'(addr), 'h200);
        dev_req = 1'b0;
        repeat (10) @(negedge clk);

        // sweep counts and command options
        for (int c = 0; c < 8; c++) begin
            for (int n = 0; n < 5; n++) begin
                run_xfer(16'h1000 + 16'(c * 64 + n * 8), n, 4'(c << 1));
            end
        end

        // R6 wrap of the address past the top
        run_xfer(16'hFFFE, 3, 4'b0000);

        // R8 abort after three bytes
        setup(16'h0300, 10, 4'b0000);
        @(negedge clk);
        dev_req = 1'b1;
        cnt = 0;
        for (int i = 0; i < 200 && cnt < 6; i++) begin
            @(negedge clk);
            if (rd_stb) cnt++;
        end
        eop_n_in = 1'b0;
        dev_req = 1'b0;
        @(negedge clk);
        check(!hold_req && !addr_en && !rd_stb && !wr_stb, "R8 abort releases bus", int'(addr_en), 0);
        check(eop_n_out == 1'b1, "R8 no end pulse on abort", int'(eop_n_out), 1);
        check(done == 1'b1, "R8 R13 done after abort", int'(done), 1);
        eop_n_in = 1'b1;
        repeat (5) @(negedge clk);
        check(!hold_req, "R8 stays idle after abort", int'(hold_req), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule